// File: doc/BRIEF.md
# Gate Driver Protection Sequencer

This block is a synchronous controller placed between a logic-level on/off command and the turn-on request of a power-switch gate driver. It passes a high command through to a registered gate request, with two protections wrapped around it. The first is a lockout against a weak floating supply. A digital undervoltage flag is sampled only while the command is low. If that sample shows a weak supply when the command rises, the turn-on is refused.

The second protection guards the switch voltage. Every accepted turn-on starts a blanking interval of about two microseconds, sized from the clock frequency parameter. During that interval an overvoltage-across-switch flag is ignored. After it, a trip of that flag forces the gate request low and sets a latched fault, even though the command is still high. A low command always returns the controller to idle. The fault indication stays visible until the next rising command edge, which is the only event that clears it.

All three inputs pass through two-flop synchronizers, and every output is registered. Analog sensing, current limiting, slew control and level shifting are handled outside this block.

Top module: `gate_prot_seq`

## Requirements
- R1: With a good supply, a rising edge on `cmd_in` drives `gate_on` high on the third rising clock edge after the input changes (two synchronizer stages plus the output register).
- R2: A low `cmd_in` drives `gate_on` low on the third clock edge after the input falls, from any state.
- R3: If `uv_flag` was high in the last synchronized cycle in which the command was low, a rising command edge is refused: `gate_on` stays 0 and `uv_blocked` becomes 1.
- R4: A refused edge never turns the gate on later, even if `uv_flag` clears while the command stays high. Only a later rising edge taken with a good supply turns the gate on, and that edge returns `uv_blocked` to 0.
- R5: `uv_flag` going high while the command is high has no effect on `gate_on`.
- R6: After each accepted turn-on, `ov_flag` is ignored for BLANK_CYCLES clocks (the clock frequency times 2 µs, which is 200 at 100 MHz). With `ov_flag` held high throughout, `gate_on` stays high for exactly BLANK_CYCLES+1 clocks.
- R7: A synchronized `ov_flag` seen after blanking, with the command high, drives `gate_on` low and `fault_latched` high on the next clock. Both are held while the command stays high.
- R8: `fault_latched` stays 1 after the command falls and clears on the next rising command edge.
- R9: If the command falls and `ov_flag` rises in the same synchronized cycle while the gate is on, the gate turns off without setting `fault_latched`.
- R10: A synchronous active-high `rst` drives `gate_on`, `fault_latched` and `uv_blocked` to 0 and returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 1 | Asynchronous gate command, high requests on |
| uv_flag | input | 1 | Asynchronous floating-supply undervoltage flag, high means weak |
| ov_flag | input | 1 | Asynchronous switch overvoltage flag, high means tripped |
| gate_on | output | 1 | Registered gate turn-on request |
| fault_latched | output | 1 | Registered overvoltage fault indication |
| uv_blocked | output | 1 | Registered flag, last rising edge refused for undervoltage |

## Verification
Two events can land on the same clock: the end of the blanking interval and an overvoltage trip. The bench holds `ov_flag` high before it raises the command. It then counts how many clocks `gate_on` stays high. The expected count is exactly BLANK_CYCLES+1: the flag must be ignored on the last blanking cycle and must trip on the first cycle after blanking. A second collision, a command fall arriving together with an overvoltage trip, is provoked by changing both inputs on the same cycle. It is judged by checking that `fault_latched` stays 0 while `gate_on` drops.

// File: rtl/gdp_pkg.sv
package gdp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_DRIVE = 2'd2,
    ST_TRIP  = 2'd3
  } gdp_state_t;

  function automatic int blank_cycles_calc(input int clk_hz, input int blank_ns);
    longint prod;
    prod = (longint'(clk_hz) * longint'(blank_ns)) / 64'd1000000000;
    if (prod < 1) prod = 1;
    return int'(prod);
  endfunction

endpackage

// File: rtl/gdp_sync.sv
module gdp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/gdp_blank_timer.sv
module gdp_blank_timer #(
  parameter int BLANK_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam int CNT_W = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BLANK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOAD_VAL;
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD_VAL); // R6
  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == LOAD_VAL)); // R6

endmodule

// File: rtl/gdp_ctrl.sv
module gdp_ctrl
  import gdp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_s,
  input  logic uv_s,
  input  logic ov_s,
  input  logic blank_done,
  output logic blank_load,
  output logic blank_run,
  output logic gate_on,
  output logic fault_latched,
  output logic uv_blocked
);

  gdp_state_t state, state_n;
  logic cmd_d;
  logic uv_hold;
  logic rise;
  logic fault_n, uvb_n;

  assign rise = cmd_s && !cmd_d;

  // supply is sampled only while the command is low
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_d   <= 1'b0;
      uv_hold <= 1'b0;
    end else begin
      cmd_d <= cmd_s;
      if (!cmd_s) uv_hold <= uv_s;
    end
  end

  always_comb begin
    state_n    = state;
    fault_n    = fault_latched;
    uvb_n      = uv_blocked;
    blank_load = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rise) begin
          fault_n = 1'b0;
          uvb_n   = uv_hold;
          if (!uv_hold) begin
            state_n    = ST_BLANK;
            blank_load = 1'b1;
          end
        end
      end
      ST_BLANK: begin
        if (!cmd_s)          state_n = ST_IDLE;
        else if (blank_done) state_n = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (!cmd_s) begin
          state_n = ST_IDLE;
        end else if (ov_s) begin
          state_n = ST_TRIP;
          fault_n = 1'b1;
        end
      end
      ST_TRIP: begin
        if (!cmd_s) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign blank_run = (state == ST_BLANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      gate_on       <= 1'b0;
      fault_latched <= 1'b0;
      uv_blocked    <= 1'b0;
    end else begin
      state         <= state_n;
      gate_on       <= (state_n == ST_BLANK) || (state_n == ST_DRIVE);
      fault_latched <= fault_n;
      uv_blocked    <= uvb_n;
    end
  end

  AST_GATE_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    gate_on |-> $past(cmd_s)); // R2
  AST_UV_REFUSES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rise && uv_hold) |=> (!gate_on && uv_blocked)); // R3
  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLANK && cmd_s) |=> gate_on); // R6
  AST_OV_TRIPS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRIVE && cmd_s && ov_s) |=> (!gate_on && fault_latched)); // R7
  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rise) |=> !fault_latched); // R8
  AST_FALL_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (!cmd_s && !fault_latched) |=> (!gate_on && !fault_latched)); // R9

endmodule

// File: rtl/gate_prot_seq.sv
module gate_prot_seq
  import gdp_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int BLANK_NS    = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_in,
  input  logic uv_flag,
  input  logic ov_flag,
  output logic gate_on,
  output logic fault_latched,
  output logic uv_blocked
);

  localparam int BLANK_CYCLES = blank_cycles_calc(CLK_FREQ_HZ, BLANK_NS);
  localparam int N_IN = 3;

  logic [N_IN-1:0] raw_in, sync_out;
  logic blank_load, blank_run, blank_done;

  assign raw_in = {ov_flag, uv_flag, cmd_in};

  gdp_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  gdp_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (blank_load),
    .run  (blank_run),
    .done (blank_done)
  );

  gdp_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cmd_s         (sync_out[0]),
    .uv_s          (sync_out[1]),
    .ov_s          (sync_out[2]),
    .blank_done    (blank_done),
    .blank_load    (blank_load),
    .blank_run     (blank_run),
    .gate_on       (gate_on),
    .fault_latched (fault_latched),
    .uv_blocked    (uv_blocked)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!gate_on && !fault_latched && !uv_blocked)); // R10
  AST_NO_GATE_IN_FAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_latched) |-> !gate_on); // R7

endmodule

// File: tb/gate_prot_seq_tb_top.sv
module gate_prot_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 200;

  typedef struct packed {
    logic        cmd;
    logic        uv;
    logic        ov;
    logic [15:0] wt;
    logic        eg;
    logic        ef;
    logic        eu;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'd5,   1'b0, 1'b0, 1'b0, 8'd2},  // R2 idle
    '{1'b1, 1'b0, 1'b0, 16'd5,   1'b1, 1'b0, 1'b0, 8'd1},  // R1 on
    '{1'b1, 1'b0, 1'b1, 16'd100, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 ov in blanking
    '{1'b1, 1'b0, 1'b1, 16'd120, 1'b0, 1'b1, 1'b0, 8'd7},  // R7 trip
    '{1'b1, 1'b0, 1'b0, 16'd10,  1'b0, 1'b1, 1'b0, 8'd7},  // R7 held
    '{1'b0, 1'b0, 1'b0, 16'd5,   1'b0, 1'b1, 1'b0, 8'd8},  // R8 held low
    '{1'b1, 1'b0, 1'b0, 16'd5,   1'b1, 1'b0, 1'b0, 8'd8},  // R8 cleared
    '{1'b1, 1'b1, 1'b0, 16'd300, 1'b1, 1'b0, 1'b0, 8'd5},  // R5 uv while on
    '{1'b0, 1'b1, 1'b0, 16'd5,   1'b0, 1'b0, 1'b0, 8'd2},  // R2 off
    '{1'b1, 1'b1, 1'b0, 16'd5,   1'b0, 1'b0, 1'b1, 8'd3},  // R3 refused
    '{1'b1, 1'b0, 1'b0, 16'd5,   1'b0, 1'b0, 1'b1, 8'd4},  // R4 no late turn-on
    '{1'b0, 1'b0, 1'b0, 16'd5,   1'b0, 1'b0, 1'b1, 8'd4},  // R4 still flagged
    '{1'b1, 1'b0, 1'b0, 16'd5,   1'b1, 1'b0, 1'b0, 8'd4},  // R4 new edge ok
    '{1'b1, 1'b0, 1'b0, 16'd250, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 stays on
    '{1'b0, 1'b0, 1'b0, 16'd5,   1'b0, 1'b0, 1'b0, 8'd2}   // R2 off
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_in = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
  logic gate_on, fault_latched, uv_blocked;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_prot_seq dut_i (
    .clk           (clk),
    .rst           (rst),
    .cmd_in        (cmd_in),
    .uv_flag       (uv_flag),
    .ov_flag       (ov_flag),
    .gate_on       (gate_on),
    .fault_latched (fault_latched),
    .uv_blocked    (uv_blocked)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string what, input int req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    int hi;
    step(3);
    chk("reset gate_on", 10, gate_on, 0);        // R10
    chk("reset fault", 10, fault_latched, 0);    // R10
    chk("reset uv_blocked", 10, uv_blocked, 0);  // R10
    rst = 1'b0;
    step(2);

    for (int i = 0; i < NV; i++) begin
      cmd_in = VEC[i].cmd; uv_flag = VEC[i].uv; ov_flag = VEC[i].ov;
      step(int'(VEC[i].wt));
      chk($sformatf("row %0d gate_on", i), VEC[i].req, gate_on, VEC[i].eg);
      chk($sformatf("row %0d fault", i), VEC[i].req, fault_latched, VEC[i].ef);
      chk($sformatf("row %0d uv_blocked", i), VEC[i].req, uv_blocked, VEC[i].eu);
    end

    // R1 exact turn-on latency, R2 exact turn-off latency
    cmd_in = 1'b1;
    step(2);
    chk("gate before third edge", 1, gate_on, 0);  // R1
    step(1);
    chk("gate at third edge", 1, gate_on, 1);      // R1
    step(5);
    cmd_in = 1'b0;
    step(2);
    chk("gate before off latency", 2, gate_on, 1); // R2
    step(1);
    chk("gate off at third edge", 2, gate_on, 0);  // R2
    step(5);

    // R6 blanking end meets ov trip: gate high exactly BLANK+1 clocks
    ov_flag = 1'b1;
    cmd_in = 1'b1;
    hi = 0;
    for (int k = 0; k < BLANK + 30; k++) begin
      step(1);
      if (gate_on) hi++;
    end
    chk("gate high clocks with ov held", 6, hi, BLANK + 1); // R6
    chk("fault after blanking", 7, fault_latched, 1);       // R7
    cmd_in = 1'b0; ov_flag = 1'b0;
    step(5);

    // R9 command fall and ov trip together
    cmd_in = 1'b1;
    step(BLANK + 10);
    chk("on before collision", 9, gate_on, 1);
    cmd_in = 1'b0; ov_flag = 1'b1;
    step(6);
    chk("gate off after collision", 9, gate_on, 0);         // R9
    chk("no fault after collision", 9, fault_latched, 0);   // R9
    ov_flag = 1'b0;
    step(3);

    // R10 reset while driving
    cmd_in = 1'b1;
    step(BLANK + 10);
    rst = 1'b1;
    step(1);
    chk("reset clears gate", 10, gate_on, 0);  // R10
    cmd_in = 1'b0;
    step(3);
    rst = 1'b0;
    step(2);

    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule